// File: doc/BRIEF.md
# DMA Page-Boundary Transfer Splitter

This block sits between a disk-transfer engine and the logic that programs an 8-bit DMA channel. It takes one block request, made of a sector count and a 20-bit physical start address (a 4-bit page above a 16-bit offset). It turns the request into one or two DMA segments. The DMA channel can only increment the low 16 address bits, so no segment may cross a 64 KiB page. The block sends a segment only if it stays inside the current page. If the request runs past the page end, the first segment fills the page up to its end and the second segment starts at offset zero of the next page.

Each segment goes to the downstream programming logic as a page, an offset and a byte count, using a valid/ready handshake. The block then waits for a done pulse before it advances its address and offers the next segment. After the final done pulse, the advanced 20-bit address can be read on the address outputs, ready for the next block of a longer transfer. Requests with an illegal size are refused with a one-cycle error pulse.

Top module: `dps_page_splitter`

## Requirements
- R1: A request of N sectors (1 to 64) is N*512 bytes. When the start offset is zero, the whole amount goes out as one segment at the request's page and offset.
- R2: When the offset is nonzero and the byte count is at most 65536 minus the offset, exactly one segment carries the whole byte count.
- R3: When the byte count is greater than 65536 minus the offset, two segments are issued in this order. The first starts at the request address with length 65536 minus the offset. The second starts at offset 0 of the next page and carries the remaining bytes.
- R4: On each accepted done pulse, the 16-bit offset is increased by the segment's byte count. Any carry out of bit 15 increments the 4-bit page, which wraps from 15 to 0. The address outputs show the result from the following cycle.
- R5: A request with 0 sectors or more than 64 sectors is refused. err is high for exactly the one cycle after acceptance, no segment is issued, busy stays low and the address outputs do not change.
- R6: busy rises in the cycle after an accepted legal request and falls in the cycle after the last segment's done pulse. req_ready equals not busy. A request presented while busy has no effect.
- R7: While seg_valid is high and seg_ready is low, seg_valid stays high and seg_page, seg_offset and seg_bytes hold their values.
- R8: After a segment's handshake, seg_valid stays low until a done pulse arrives. A done pulse while a segment is still being offered is ignored.
- R9: Every issued segment satisfies offset + byte count <= 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_sectors | input | 8 | Request size in 512-byte sectors |
| req_page | input | 4 | Start address bits 19..16 |
| req_offset | input | 16 | Start address bits 15..0 |
| busy | output | 1 | A legal request is in progress |
| err | output | 1 | One-cycle pulse after a refused request |
| seg_valid | output | 1 | Segment offered downstream |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_page | output | 4 | Segment page |
| seg_offset | output | 16 | Segment start offset |
| seg_bytes | output | 16 | Segment length in bytes |
| seg_done | input | 1 | Downstream finished the current segment |
| addr_page | output | 4 | Current page (advanced after each done) |
| addr_offset | output | 16 | Current offset (advanced after each done) |

## Verification
The bench targets the split boundary from both sides.

- An offset of 0x8000 with 64 sectors exactly fills the page. A design that used a strict comparison would split it into a zero-length second segment.
- An offset of zero must not be treated as "no room left". Getting this wrong would issue a zero-byte first segment.
- A one-byte first segment at offset 0xFFFF of page 15 tests the carry into the page and the wrap of the page to 0. A design that dropped the carry would start the second segment back at the old page.

The bench also checks refused sizes 0 and 65, requests and done pulses that arrive at the wrong time, and long ready stalls. A design that leaked any of these would emit extra segments or change the segment fields during a stall.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } dps_state_e;
endpackage

// File: rtl/dps_split_calc.sv
// Computes the first and remaining segment lengths for a request.
module dps_split_calc #(
   parameter int OFS_W      = 16,
   parameter int SECT_W     = 8,
   parameter int SECT_SHIFT = 9,
   parameter int MAX_SECT   = 64,
   parameter int BYTES_W    = 16
) (
   input  logic [SECT_W-1:0]  sectors,
   input  logic [OFS_W-1:0]   offset,
   output logic               bad,
   output logic [BYTES_W-1:0] first_bytes,
   output logic [BYTES_W-1:0] rest_bytes
);
   localparam int CW = OFS_W + 1;

   logic [CW-1:0] total_w;
   logic [CW-1:0] room_w;
   logic          fits;

   assign bad     = (sectors == '0) || (int'(sectors) > MAX_SECT);
   assign total_w = CW'(sectors) << SECT_SHIFT;
   // space left in the page: 2^OFS_W minus offset (full page when offset is 0)
   assign room_w  = {1'b1, {OFS_W{1'b0}}} - {1'b0, offset};
   assign fits    = total_w <= room_w;

   always_comb begin
      if (fits) begin
         first_bytes = BYTES_W'(total_w);
         rest_bytes  = '0;
      end else begin
         first_bytes = BYTES_W'(room_w);
         rest_bytes  = BYTES_W'(total_w - room_w);
      end
   end
endmodule

// File: rtl/dps_addr_adv.sv
// Adds a segment length to the offset and carries into the page.
module dps_addr_adv #(
   parameter int PAGE_W  = 4,
   parameter int OFS_W   = 16,
   parameter int BYTES_W = 16
) (
   input  logic [PAGE_W-1:0]  page,
   input  logic [OFS_W-1:0]   offset,
   input  logic [BYTES_W-1:0] bytes,
   output logic [PAGE_W-1:0]  next_page,
   output logic [OFS_W-1:0]   next_offset
);
   logic [OFS_W:0] sum;

   assign sum         = {1'b0, offset} + (OFS_W+1)'(bytes);
   assign next_offset = sum[OFS_W-1:0];
   assign next_page   = page + PAGE_W'(sum[OFS_W]);
endmodule

// File: rtl/dps_page_splitter.sv
module dps_page_splitter #(
   parameter int PAGE_W     = 4,
   parameter int OFS_W      = 16,
   parameter int SECT_W     = 8,
   parameter int SECT_SHIFT = 9,
   parameter int MAX_SECT   = 64,
   localparam int BYTES_W   = $clog2(MAX_SECT) + SECT_SHIFT + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [SECT_W-1:0]  req_sectors,
   input  logic [PAGE_W-1:0]  req_page,
   input  logic [OFS_W-1:0]   req_offset,
   output logic               busy,
   output logic               err,
   output logic               seg_valid,
   input  logic               seg_ready,
   output logic [PAGE_W-1:0]  seg_page,
   output logic [OFS_W-1:0]   seg_offset,
   output logic [BYTES_W-1:0] seg_bytes,
   input  logic               seg_done,
   output logic [PAGE_W-1:0]  addr_page,
   output logic [OFS_W-1:0]   addr_offset
);
   import dps_pkg::*;

   generate
      if (BYTES_W > OFS_W) begin : g_bad_size
         $error("largest block must fit within one page width");
      end
      if ((1 << SECT_W) <= MAX_SECT) begin : g_bad_sect
         $error("SECT_W too narrow to express MAX_SECT and above");
      end
   endgenerate

   dps_state_e         state_q;
   logic [PAGE_W-1:0]  page_q;
   logic [OFS_W-1:0]   ofs_q;
   logic [BYTES_W-1:0] len_q;
   logic [BYTES_W-1:0] rest_q;
   logic               err_q;

   logic               req_bad;
   logic [BYTES_W-1:0] first_len;
   logic [BYTES_W-1:0] rest_len;
   logic [PAGE_W-1:0]  nxt_page;
   logic [OFS_W-1:0]   nxt_ofs;

   dps_split_calc #(
      .OFS_W(OFS_W), .SECT_W(SECT_W), .SECT_SHIFT(SECT_SHIFT),
      .MAX_SECT(MAX_SECT), .BYTES_W(BYTES_W)
   ) u_calc (
      .sectors(req_sectors), .offset(req_offset), .bad(req_bad),
      .first_bytes(first_len), .rest_bytes(rest_len)
   );

   dps_addr_adv #(
      .PAGE_W(PAGE_W), .OFS_W(OFS_W), .BYTES_W(BYTES_W)
   ) u_adv (
      .page(page_q), .offset(ofs_q), .bytes(len_q),
      .next_page(nxt_page), .next_offset(nxt_ofs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         page_q  <= '0;
         ofs_q   <= '0;
         len_q   <= '0;
         rest_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (req_bad) begin
                     err_q <= 1'b1;
                  end else begin
                     page_q  <= req_page;
                     ofs_q   <= req_offset;
                     len_q   <= first_len;
                     rest_q  <= rest_len;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (seg_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (seg_done) begin
                  page_q <= nxt_page;
                  ofs_q  <= nxt_ofs;
                  if (rest_q != '0) begin
                     len_q   <= rest_q;
                     rest_q  <= '0;
                     state_q <= ST_ISSUE;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign req_ready   = (state_q == ST_IDLE);
   assign err         = err_q;
   assign seg_valid   = (state_q == ST_ISSUE);
   assign seg_page    = page_q;
   assign seg_offset  = ofs_q;
   assign seg_bytes   = len_q;
   assign addr_page   = page_q;
   assign addr_offset = ofs_q;
endmodule

// File: rtl/dps_page_splitter_chk.sv
module dps_page_splitter_chk #(
   parameter int PAGE_W  = 4,
   parameter int OFS_W   = 16,
   parameter int BYTES_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               busy,
   input logic               err,
   input logic               seg_valid,
   input logic               seg_ready,
   input logic [PAGE_W-1:0]  seg_page,
   input logic [OFS_W-1:0]   seg_offset,
   input logic [BYTES_W-1:0] seg_bytes
);
   // R6
   busy_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> busy);

   // R6
   no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   // R7
   hold_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=>
         (seg_valid && $stable(seg_page) && $stable(seg_offset) && $stable(seg_bytes)));

   // R9
   page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (({1'b0, seg_offset} + (OFS_W+1)'(seg_bytes)) <= {1'b1, {OFS_W{1'b0}}}));

   // R5
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !seg_valid));

   // R3
   nonzero_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_bytes != '0));
endmodule

bind dps_page_splitter dps_page_splitter_chk #(
   .PAGE_W(PAGE_W), .OFS_W(OFS_W), .BYTES_W(BYTES_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .err(err),
   .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_page(seg_page),
   .seg_offset(seg_offset), .seg_bytes(seg_bytes)
);

// File: tb/dps_page_splitter_bench.sv
module dps_page_splitter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_sectors = '0;
   logic [3:0]  req_page = '0;
   logic [15:0] req_offset = '0;
   logic        busy, err, seg_valid;
   logic        seg_ready = 1'b0;
   logic [3:0]  seg_page;
   logic [15:0] seg_offset;
   logic [15:0] seg_bytes;
   logic        seg_done = 1'b0;
   logic [3:0]  addr_page;
   logic [15:0] addr_offset;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   dps_page_splitter u_dps_page_splitter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_sectors(req_sectors), .req_page(req_page), .req_offset(req_offset),
      .busy(busy), .err(err), .seg_valid(seg_valid), .seg_ready(seg_ready),
      .seg_page(seg_page), .seg_offset(seg_offset), .seg_bytes(seg_bytes),
      .seg_done(seg_done), .addr_page(addr_page), .addr_offset(addr_offset)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // model of one legal request: expected segments and final address
   task automatic run_req(input int sect, input int pg, input int ofs,
                          input int rlat, input int dlat, input bit poke);
      int total = sect * 512;
      int room  = 65536 - ofs;
      int nseg  = (total <= room) ? 1 : 2;
      int e_pg  = pg;
      int e_of  = ofs;
      string tag = (nseg == 2) ? "R3" : ((ofs == 0) ? "R1" : "R2");
      @(negedge clk);
      check(req_ready == 1'b1, "R6 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_sectors = 8'(sect); req_page = 4'(pg); req_offset = 16'(ofs);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == 1'b1, "R6 busy after accept", busy, 1);
      for (int s = 0; s < nseg; s++) begin
         int len = (s == 0) ? ((nseg == 1) ? total : room) : (total - room);
         int w = 0;
         while (!seg_valid && w < 50) begin @(negedge clk); w++; end
         check(seg_valid == 1'b1, {tag, " segment offered"}, seg_valid, 1);
         check(seg_page == 4'(e_pg), {tag, " seg page"}, seg_page, e_pg);
         check(seg_offset == 16'(e_of), {tag, " seg offset"}, seg_offset, e_of);
         check(seg_bytes == 16'(len), {tag, " seg bytes"}, seg_bytes, len);
         check(int'(seg_offset) + int'(seg_bytes) <= 65536, "R9 within page",
               int'(seg_offset) + int'(seg_bytes), 65536);
         for (int k = 0; k < rlat; k++) begin
            seg_done = poke && (k == 0);
            @(negedge clk);
            seg_done = 1'b0;
            check(seg_valid && seg_page == 4'(e_pg) && seg_offset == 16'(e_of)
                  && seg_bytes == 16'(len), "R7 held during stall", seg_bytes, len);
            if (poke && k == 0)
               check(addr_offset == 16'(e_of), "R8 early done ignored", addr_offset, e_of);
         end
         seg_ready = 1'b1;
         @(negedge clk);
         seg_ready = 1'b0;
         check(seg_valid == 1'b0, "R8 no segment before done", seg_valid, 0);
         for (int k = 0; k < dlat; k++) begin
            if (poke) begin req_valid = 1'b1; req_sectors = 8'd3; req_offset = 16'h0; end
            @(negedge clk);
            check(req_ready == 1'b0, "R6 not ready while busy", req_ready, 0);
            check(seg_valid == 1'b0, "R8 waiting for done", seg_valid, 0);
            req_valid = 1'b0;
         end
         e_of = e_of + len;
         if (e_of >= 65536) begin e_of -= 65536; e_pg = (e_pg + 1) % 16; end
         seg_done = 1'b1;
         @(negedge clk);
         seg_done = 1'b0;
         check(addr_page == 4'(e_pg), "R4 page advance", addr_page, e_pg);
         check(addr_offset == 16'(e_of), "R4 offset advance", addr_offset, e_of);
         check(busy == (s != nseg - 1), "R6 busy until last done", busy, (s != nseg - 1));
      end
      @(negedge clk);
      check(seg_valid == 1'b0 && busy == 1'b0, "R6 no extra segment", seg_valid, 0);
   endtask

   task automatic run_bad(input int sect);
      logic [3:0]  p0;
      logic [15:0] o0;
      @(negedge clk);
      p0 = addr_page; o0 = addr_offset;
      req_valid = 1'b1; req_sectors = 8'(sect); req_page = 4'h9; req_offset = 16'h4321;
      @(negedge clk);
      req_valid = 1'b0;
      check(err == 1'b1, "R5 err pulse", err, 1);
      check(busy == 1'b0 && seg_valid == 1'b0, "R5 no segment", busy, 0);
      @(negedge clk);
      check(err == 1'b0, "R5 err one cycle", err, 0);
      check(addr_page == p0 && addr_offset == o0, "R5 address kept", addr_offset, o0);
      check(seg_valid == 1'b0, "R5 still no segment", seg_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && seg_valid == 1'b0 && err == 1'b0, "R6 reset idle", busy, 0);
      check(req_ready == 1'b1, "R6 reset ready", req_ready, 1);
      check(addr_page == 4'h0 && addr_offset == 16'h0, "R4 reset address", addr_offset, 0);
      run_req(64, 3, 16'h0000, 0, 1, 1'b0);   // R1 full block at page start
      run_req(3, 5, 16'h1234, 2, 2, 1'b0);    // R2 fits
      run_req(64, 7, 16'h8000, 1, 0, 1'b0);   // R2 exact fill, carry to page 8
      run_req(16, 2, 16'hFF00, 3, 2, 1'b1);   // R3 split with early done and busy request
      run_req(1, 15, 16'hFFFF, 0, 1, 1'b0);   // R3 one-byte first segment, page wraps to 0
      run_req(64, 1, 16'h8001, 2, 0, 1'b1);   // R3 split by one byte
      run_bad(0);
      run_bad(65);
      run_bad(255);
      run_req(1, 0, 16'h0000, 0, 0, 1'b0);    // R1 smallest request
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule